// File: doc/BRIEF.md
# Debug Watchpoint Register Bank

This block holds a configurable number of hardware watchpoint pairs for a processor core. Each pair has a low register, which holds a watched address and three access-kind enables, and a high register, which holds an address-space identifier, a global flag, an address-ignore mask, a read-only chain flag and three sticky match-status bits. Software reaches both registers through a simple register port. The read side is combinational.

The core presents memory-access events on a valid/ready stream. Each event carries a virtual address, an access kind and the current address-space identifier. The bank never applies back-pressure: `ev_ready` is always high, so an event transfers in every cycle where `ev_valid` is high. Each transferred event is compared against every pair at once. Every matching pair records the kind in its status bits. One clock later the block drives a single-cycle watch pulse, together with the vector of pairs that matched and the one-hot kind.

Only the enable bits and mask bits that the implementation supports are writable, and both sets are fixed by parameters. Software can therefore discover them by writing ones and reading back. It can also count the pairs by following the chain flags.

Top module: `wp_bank`

## Requirements
- R1: In a low register, bits 31:3 hold the watched address and bits 2:0 hold the enables: bit 2 for instruction fetch, bit 1 for load and bit 0 for store. An enable bit that is not in `EN_SUP` reads back as zero after a one is written to it.
- R2: In a high register, bits 11:3 are the address-ignore mask. Bit 3+k stands for address bit 3+k. A mask bit that is not in `MASK_SUP` reads back as zero after a one is written to it.
- R3: Bit 31 of a high register reads as one for every pair except the last one, where it reads as zero. Writes do not change it.
- R4: Bit 30 of a high register is the global flag, and bits 23:16 hold the pair's identifier. When the global flag is clear, a pair matches only if its identifier equals `ev_asid`. When the flag is set, the identifier is not compared.
- R5: The address comparison ignores bits 2:0. It also ignores each address bit whose mask bit is set. All other bits 31:3 must be equal.
- R6: A pair matches only if the enable for the event's kind is set. The kind encoding is 0 for fetch, 1 for load, 2 for store, and 3 matches nothing. A pair whose enables are all zero never matches.
- R7: Bits 2:0 of a high register are sticky status bits, in the same order as the enables. A match sets the bit for its kind. Writing a one to a status bit clears it, and writing a zero leaves it unchanged. If a clear and a match hit the same bit in the same cycle, the bit ends up set.
- R8: One cycle after an accepted event that matches at least one pair, `wexc` pulses high for one cycle. `wexc_hits` then shows every matching pair, and `wexc_kind` is the one-hot kind in the enable order. All matching pairs record status. In every other cycle `wexc`, `wexc_hits` and `wexc_kind` are zero.
- R9: After reset, every enable, status bit, global flag, address, identifier and mask reads as zero. Only the chain bits read as one.
- R10: `ev_ready` is high in every cycle.
- R11: Selecting an index at or above `NPAIR` reads zero, and writes to such an index are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_we | input | 1 | Write strobe for the selected register |
| cfg_hi | input | 1 | 1 selects the high register, 0 selects the low register |
| cfg_idx | input | 3 | Pair index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data of the selected register |
| ev_valid | input | 1 | Access event is valid |
| ev_ready | output | 1 | Always high |
| ev_va | input | 32 | Virtual address of the access |
| ev_kind | input | 2 | 0 fetch, 1 load, 2 store |
| ev_asid | input | 8 | Current address-space identifier |
| wexc | output | 1 | Single-cycle watch pulse |
| wexc_hits | output | NPAIR | Pairs that matched |
| wexc_kind | output | 3 | One-hot matched kind (bit 2 fetch, bit 1 load, bit 0 store) |

## Verification
Read data is combinational, so the value a write leaves in a register is due in the cycle after that write's edge. The watch pulse, the hit vector and the kind appear exactly one edge after the event transfers. The status bits are visible on a read in the following cycle. The bench drives on the falling edge and compares `cfg_rdata` and `ev_ready` 1 ns later. After each rising edge it advances a behavioural model and compares the registered outputs 1 ns after that edge. A result arriving a cycle early or late therefore shows up as a mismatch.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  // one-hot kind in enable order: [2]=fetch [1]=load [0]=store
  function automatic logic [2:0] kind_bits(input logic [1:0] k);
    case (acc_e'(k))
      ACC_FETCH: kind_bits = 3'b100;
      ACC_LOAD:  kind_bits = 3'b010;
      ACC_STORE: kind_bits = 3'b001;
      default:   kind_bits = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/wp_pair.sv
module wp_pair #(
  parameter int          DW       = 32,
  parameter int          ASID_W   = 8,
  parameter logic [2:0]  EN_SUP   = 3'b111,
  parameter logic [8:0]  MASK_SUP = 9'h1FF,
  parameter bit          LAST     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DW-1:0]     wdata,
  input  logic              ev_fire,
  input  logic [DW-1:0]     ev_va,
  input  logic [2:0]        ev_kb,
  input  logic [ASID_W-1:0] ev_asid,
  output logic [DW-1:0]     lo_rd,
  output logic [DW-1:0]     hi_rd,
  output logic              hit
);
  localparam int AW = DW - 3;

  logic [AW-1:0]     addr_q;
  logic [2:0]        en_q;
  logic              g_q;
  logic [ASID_W-1:0] asid_q;
  logic [8:0]        mask_q;
  logic [2:0]        st_q;

  logic [AW-1:0] cmp_keep;
  logic          addr_ok, asid_ok;
  logic [2:0]    kind_hit;
  logic [2:0]    st_clr;

  // address bits 11:3 can be ignored, higher bits always compared
  assign cmp_keep = {{(DW-12){1'b1}}, ~mask_q};
  assign addr_ok  = ((ev_va[DW-1:3] ^ addr_q) & cmp_keep) == '0;
  assign asid_ok  = g_q || (asid_q == ev_asid);
  assign kind_hit = en_q & ev_kb;
  assign hit      = ev_fire && addr_ok && asid_ok && (kind_hit != 3'b000);
  assign st_clr   = wr_hi ? wdata[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      en_q   <= '0;
      g_q    <= 1'b0;
      asid_q <= '0;
      mask_q <= '0;
      st_q   <= '0;
    end else begin
      if (wr_lo) begin
        addr_q <= wdata[DW-1:3];
        en_q   <= wdata[2:0] & EN_SUP;
      end
      if (wr_hi) begin
        g_q    <= wdata[30];
        asid_q <= wdata[16 +: ASID_W];
        mask_q <= wdata[11:3] & MASK_SUP;
      end
      // set wins over a same-cycle write-one clear
      st_q <= (st_q & ~st_clr) | (hit ? kind_hit : 3'b000);
    end
  end

  assign lo_rd = {addr_q, en_q};

  always_comb begin
    hi_rd              = '0;
    hi_rd[31]          = !LAST;
    hi_rd[30]          = g_q;
    hi_rd[16 +: ASID_W] = asid_q;
    hi_rd[11:3]        = mask_q;
    hi_rd[2:0]         = st_q;
  end
endmodule

// File: rtl/wp_evt_reg.sv
module wp_evt_reg #(
  parameter int NPAIR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] hits,
  input  logic [2:0]       kb,
  output logic             wexc,
  output logic [NPAIR-1:0] wexc_hits,
  output logic [2:0]       wexc_kind
);
  logic any_hit;
  assign any_hit = |hits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wexc      <= 1'b0;
      wexc_hits <= '0;
      wexc_kind <= '0;
    end else begin
      wexc      <= any_hit;
      wexc_hits <= hits;
      wexc_kind <= any_hit ? kb : 3'b000;
    end
  end
endmodule

// File: rtl/wp_bank.sv
module wp_bank #(
  parameter int         NPAIR    = 4,
  parameter int         DW       = 32,
  parameter int         ASID_W   = 8,
  parameter logic [2:0] EN_SUP   = 3'b111,
  parameter logic [8:0] MASK_SUP = 9'h1FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_hi,
  input  logic [2:0]        cfg_idx,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [DW-1:0]     ev_va,
  input  logic [1:0]        ev_kind,
  input  logic [ASID_W-1:0] ev_asid,
  output logic              wexc,
  output logic [NPAIR-1:0]  wexc_hits,
  output logic [2:0]        wexc_kind
);
  import wp_pkg::*;

  localparam int IDX_W = 3;

  logic [DW-1:0]    lo_rd [NPAIR];
  logic [DW-1:0]    hi_rd [NPAIR];
  logic [NPAIR-1:0] hits;
  logic [2:0]       ev_kb;
  logic             ev_fire;

  assign ev_ready = 1'b1;
  assign ev_fire  = ev_valid && ev_ready;
  assign ev_kb    = kind_bits(ev_kind);

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    logic sel;
    assign sel = (cfg_idx == IDX_W'(i));
    wp_pair #(
      .DW(DW), .ASID_W(ASID_W), .EN_SUP(EN_SUP), .MASK_SUP(MASK_SUP),
      .LAST(i == NPAIR - 1)
    ) u_pair (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(cfg_we && sel && !cfg_hi),
      .wr_hi(cfg_we && sel && cfg_hi),
      .wdata(cfg_wdata),
      .ev_fire(ev_fire), .ev_va(ev_va), .ev_kb(ev_kb), .ev_asid(ev_asid),
      .lo_rd(lo_rd[i]), .hi_rd(hi_rd[i]), .hit(hits[i])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NPAIR; i++) begin
      if (cfg_idx == IDX_W'(i)) cfg_rdata = cfg_hi ? hi_rd[i] : lo_rd[i];
    end
  end

  wp_evt_reg #(.NPAIR(NPAIR)) u_evt (
    .clk(clk), .rst_n(rst_n), .hits(hits), .kb(ev_kb),
    .wexc(wexc), .wexc_hits(wexc_hits), .wexc_kind(wexc_kind)
  );
endmodule

// File: rtl/wp_bank_chk.sv
module wp_bank_chk #(
  parameter int         NPAIR    = 4,
  parameter int         DW       = 32,
  parameter logic [2:0] EN_SUP   = 3'b111,
  parameter logic [8:0] MASK_SUP = 9'h1FF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_hi,
  input logic [2:0]       cfg_idx,
  input logic [DW-1:0]    cfg_rdata,
  input logic             ev_valid,
  input logic             wexc,
  input logic [2:0]       wexc_kind
);
  // R8
  no_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> !wexc);
  // R8
  kind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wexc |-> ($countones(wexc_kind) == 1));
  // R1
  en_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hi |-> ((cfg_rdata[2:0] & ~EN_SUP) == 3'b000));
  // R2
  mask_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hi |-> ((cfg_rdata[11:3] & ~MASK_SUP) == 9'h000));
  // R11
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cfg_idx) >= NPAIR) |-> (cfg_rdata == '0));
endmodule

bind wp_bank wp_bank_chk #(
  .NPAIR(NPAIR), .DW(DW), .EN_SUP(EN_SUP), .MASK_SUP(MASK_SUP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_hi(cfg_hi), .cfg_idx(cfg_idx),
  .cfg_rdata(cfg_rdata), .ev_valid(ev_valid), .wexc(wexc),
  .wexc_kind(wexc_kind)
);

// File: tb/wp_bank_test.sv
module wp_bank_test;
  localparam int         NP   = 3;
  localparam logic [2:0] ENS  = 3'b101;
  localparam logic [8:0] MSKS = 9'h0FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_hi = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ev_valid = 1'b0, ev_ready;
  logic [31:0] ev_va = '0;
  logic [1:0]  ev_kind = '0;
  logic [7:0]  ev_asid = '0;
  logic        wexc;
  logic [NP-1:0] wexc_hits;
  logic [2:0]  wexc_kind;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  wp_bank #(.NPAIR(NP), .EN_SUP(ENS), .MASK_SUP(MSKS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hi(cfg_hi),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_va(ev_va),
    .ev_kind(ev_kind), .ev_asid(ev_asid), .wexc(wexc),
    .wexc_hits(wexc_hits), .wexc_kind(wexc_kind)
  );

  // behavioural model
  logic [31:0] m_lo [NP];
  logic        m_g [NP];
  logic [7:0]  m_asid [NP];
  logic [8:0]  m_mask [NP];
  logic [2:0]  m_st [NP];
  logic [NP-1:0] e_hits = '0;
  logic [2:0]  e_kind = '0;

  function automatic logic [31:0] mread(input logic hi, input logic [2:0] idx);
    logic [31:0] v;
    if (int'(idx) >= NP) return 32'h0;
    if (!hi) return m_lo[idx];
    v = 32'h0;
    if (int'(idx) < NP - 1) v[31] = 1'b1;
    v[30] = m_g[idx];
    v[23:16] = m_asid[idx];
    v[11:3] = m_mask[idx];
    v[2:0] = m_st[idx];
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic we, input logic hi, input logic [2:0] idx,
                            input logic [31:0] wd, input logic ev, input logic [31:0] va,
                            input logic [1:0] k, input logic [7:0] asid);
    logic [2:0] kb;
    logic [NP-1:0] h;
    case (k)
      2'd0: kb = 3'b100;
      2'd1: kb = 3'b010;
      2'd2: kb = 3'b001;
      default: kb = 3'b000;
    endcase
    h = '0;
    for (int p = 0; p < NP; p++) begin
      bit ok;
      ok = ev && ((m_lo[p][2:0] & kb) != 0) && (m_g[p] || m_asid[p] == asid);
      for (int b = 3; b < 32; b++) begin
        if (b <= 11 && m_mask[p][b-3]) continue;
        if (va[b] != m_lo[p][b]) ok = 0;
      end
      h[p] = ok;
    end
    if (we && int'(idx) < NP) begin
      if (!hi) m_lo[idx] = {wd[31:3], wd[2:0] & ENS};
      else begin
        m_g[idx] = wd[30];
        m_asid[idx] = wd[23:16];
        m_mask[idx] = wd[11:3] & MSKS;
        m_st[idx] = m_st[idx] & ~wd[2:0];
      end
    end
    for (int p = 0; p < NP; p++) if (h[p]) m_st[p] = m_st[p] | kb;
    e_hits = h;
    e_kind = (h != 0) ? kb : 3'b000;
  endtask

  task automatic cyc(input string tag, input logic we, input logic hi,
                     input logic [2:0] idx, input logic [31:0] wd,
                     input logic ev, input logic [31:0] va,
                     input logic [1:0] k, input logic [7:0] asid);
    @(negedge clk);
    cfg_we = we; cfg_hi = hi; cfg_idx = idx; cfg_wdata = wd;
    ev_valid = ev; ev_va = va; ev_kind = k; ev_asid = asid;
    #1;
    check({tag, " rdata"}, cfg_rdata, mread(hi, idx));
    check("R10 ev_ready", {31'h0, ev_ready}, 32'h1);
    @(posedge clk);
    model_step(we, hi, idx, wd, ev, va, k, asid);
    #1;
    check({tag, " R8 wexc"}, {31'h0, wexc}, {31'h0, e_hits != 0});
    check({tag, " R8 hits"}, {29'h0, wexc_hits}, {29'h0, e_hits});
    check({tag, " R8 kind"}, {29'h0, wexc_kind}, {29'h0, e_kind});
  endtask

  task automatic rd(input string tag, input logic hi, input logic [2:0] idx);
    cyc(tag, 1'b0, hi, idx, 32'h0, 1'b0, 32'h0, 2'd3, 8'h0);
  endtask
  task automatic wr(input string tag, input logic hi, input logic [2:0] idx, input logic [31:0] d);
    cyc(tag, 1'b1, hi, idx, d, 1'b0, 32'h0, 2'd3, 8'h0);
  endtask
  task automatic evt(input string tag, input logic [31:0] va, input logic [1:0] k, input logic [7:0] a);
    cyc(tag, 1'b0, 1'b0, 3'd0, 32'h0, 1'b1, va, k, a);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_lo[p] = '0; m_g[p] = 0; m_asid[p] = '0; m_mask[p] = '0; m_st[p] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9 reset state, R3 chain bits
    rd("R9 lo0", 1'b0, 3'd0);
    rd("R3 hi0 chain", 1'b1, 3'd0);
    rd("R3 hi1 chain", 1'b1, 3'd1);
    rd("R3 hi2 last", 1'b1, 3'd2);
    check("R3 last pair chain", cfg_rdata, 32'h0);
    // R1 unsupported enable reads zero
    wr("R1 wr lo0", 1'b0, 3'd0, 32'h1000_0007);
    rd("R1 rd lo0", 1'b0, 3'd0);
    check("R1 lo0 value", cfg_rdata, 32'h1000_0005);
    // R2 mask support, R4 global; R3 chain not writable
    wr("R2 wr hi2", 1'b1, 3'd2, 32'hC000_0FFF);
    rd("R2 rd hi2", 1'b1, 3'd2);
    check("R2 hi2 value", cfg_rdata, 32'h4000_07F8);
    wr("R4 wr hi0", 1'b1, 3'd0, 32'h0012_0000);
    rd("R4 rd hi0", 1'b1, 3'd0);
    // R8 fetch hit, R7 status
    evt("R8 fetch hit", 32'h1000_0004, 2'd0, 8'h12);
    rd("R7 status I", 1'b1, 3'd0);
    check("R7 hi0 value", cfg_rdata, 32'h8012_0004);
    // R4 asid mismatch, then global
    evt("R4 asid miss", 32'h1000_0000, 2'd0, 8'h13);
    wr("R4 set G", 1'b1, 3'd0, 32'h4012_0000);
    evt("R4 global hit", 32'h1000_0000, 2'd0, 8'h13);
    // R6 load not enabled, store enabled
    evt("R6 load miss", 32'h1000_0000, 2'd1, 8'h12);
    evt("R6 kind3 miss", 32'h1000_0000, 2'd3, 8'h12);
    evt("R6 store hit", 32'h1000_0003, 2'd2, 8'h12);
    // R5 address masking
    evt("R5 addr miss", 32'h1000_0100, 2'd0, 8'h12);
    wr("R5 mask bit8", 1'b1, 3'd0, 32'h4012_0100);
    evt("R5 masked hit", 32'h1000_0100, 2'd0, 8'h12);
    evt("R5 high bit miss", 32'h1000_1100, 2'd0, 8'h12);
    // R8 multiple pairs
    wr("R8 wr lo1", 1'b0, 3'd1, 32'h1000_0004);
    wr("R8 wr hi1", 1'b1, 3'd1, 32'h4000_0000);
    evt("R8 two pairs", 32'h1000_0000, 2'd0, 8'h55);
    rd("R7 hi1 status", 1'b1, 3'd1);
    // R7 write-one clear, set wins
    wr("R7 clr I", 1'b1, 3'd0, 32'h4012_0104);
    rd("R7 after clr", 1'b1, 3'd0);
    check("R7 only W left", {29'h0, cfg_rdata[2:0]}, 32'h1);
    cyc("R7 clr vs set", 1'b1, 1'b1, 3'd0, 32'h4012_0101, 1'b1, 32'h1000_0000, 2'd2, 8'h12);
    rd("R7 set wins", 1'b1, 3'd0);
    check("R7 W kept", {29'h0, cfg_rdata[2:0]}, 32'h1);
    // R6 disable by writing zero
    wr("R6 disable lo0", 1'b0, 3'd0, 32'h0);
    wr("R6 disable lo1", 1'b0, 3'd1, 32'h0);
    evt("R6 disabled", 32'h0000_0000, 2'd0, 8'h12);
    // R11 out-of-range index
    wr("R11 wr idx5", 1'b0, 3'd5, 32'hFFFF_FFFF);
    rd("R11 rd idx5", 1'b0, 3'd5);
    rd("R11 rd idx3 hi", 1'b1, 3'd3);
    check("R11 idx3 zero", cfg_rdata, 32'h0);
    rd("R11 lo2 untouched", 1'b0, 3'd2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule